// File: doc/BRIEF.md
# Pan-and-Scan Display Fetch Generator

This block produces, one display line at a time, the stream of 64-bit word read addresses that a display pipeline needs to pull a visible window out of a stored frame buffer. The window can start at any whole-word column (8 pixels per word) and any stored row. The block also supplies the byte lane of the first visible pixel and the start phase of a downstream horizontal interpolation filter, so the image can be shifted by a whole word, a single pixel, or one eighth of a pixel.

The offset and length parameters come from one of two sets. One set is written by a host. The other is fed by a bitstream parser. A select input picks the set. The chosen set, together with the frame base address and the line pitch, is copied into shadow registers when the frame-start strobe arrives, so the window never moves partway through a frame. Each line-start strobe then issues the requests for one line on a valid/ready port. The final word of the line is flagged, and a line-done pulse follows.

Top module: `pscan_fetch_gen`

## Requirements
- R1: On a frame-start strobe the shadow parameters are taken from the bitstream inputs when `src_bitstream` is 1, and from the host inputs when it is 0.
- R2: Changes to the parameter inputs, `base_addr`, `stride_words` or `src_bitstream` between frame-start strobes have no effect on requests, lane select or filter phase until the next frame-start strobe.
- R3: For display line n of the frame (n counts accepted line starts since frame start, from 0), the first request address is base + (line_off + n) × stride + word_off, modulo 2^ADDR_W. Each following request of the line is one higher.
- R4: A line with reads value r > 0 issues exactly r accepted requests. `req_last` is 1 only on the r-th request.
- R5: With a reads value of 0, a line start issues no request, and `line_done` pulses in the cycle after the line-start strobe is sampled.
- R6: `line_done` is high for the one cycle after the final handshake of a line, and `req_valid` is low in that cycle.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_valid` and `req_addr` hold their values to the next cycle.
- R8: `byte_sel` equals the shadowed byte offset. `filt_phase` equals the shadowed sub-pixel offset when the shadowed filter enable is 1, and 0 otherwise. `filt_en_o` and `filt_sel_o` are the shadowed enable and select bits. All of these change only after a frame-start strobe.
- R9: A line-start strobe is ignored while a line is being fetched. A frame-start strobe ends any line in progress, with no line-done pulse, and restarts line numbering at 0.
- R10: After reset, `req_valid`, `req_last` and `line_done` are 0, and all shadow parameters, including the reads value, are 0.
- R11: `req_valid` rises in the cycle after an accepted line-start strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame strobe; latches the shadow parameters |
| line_start | input | 1 | Starts fetching the next display line |
| src_bitstream | input | 1 | 1: use bitstream set; 0: use host set |
| base_addr | input | ADDR_W | Word address of stored frame row 0, column 0 |
| stride_words | input | STRIDE_W | Line pitch in 64-bit words |
| host_word_off | input | 8 | Host horizontal offset in words |
| host_byte_off | input | 3 | Host byte offset within first word |
| host_sub_off | input | 3 | Host 1/8-pixel filter start phase |
| host_filt_en | input | 1 | Host horizontal filter enable |
| host_filt_sel | input | 1 | Host horizontal filter select |
| host_reads | input | 7 | Host words fetched per line |
| host_line_off | input | 8 | Host first displayed stored line |
| bs_word_off | input | 8 | Bitstream horizontal offset in words |
| bs_byte_off | input | 3 | Bitstream byte offset |
| bs_sub_off | input | 3 | Bitstream 1/8-pixel phase |
| bs_filt_en | input | 1 | Bitstream filter enable |
| bs_filt_sel | input | 1 | Bitstream filter select |
| bs_reads | input | 7 | Bitstream words per line |
| bs_line_off | input | 8 | Bitstream first displayed line |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Word address of the request |
| req_last | output | 1 | Final request of the line |
| line_done | output | 1 | One-cycle pulse at end of a line |
| byte_sel | output | 3 | Byte lane of first displayed pixel |
| filt_phase | output | 3 | Filter start phase |
| filt_en_o | output | 1 | Filter enable to the filter |
| filt_sel_o | output | 1 | Filter select to the filter |

## Verification
A corrupted word counter shows up at the request port within the line it affects, as a missing or extra handshake, a misplaced `req_last`, or a `line_done` pulse at the wrong time. A wrong line index or a bad shadow value shows up in the first request address of the next line. A shadow register that updates mid-frame changes `byte_sel` or `filt_phase` in the same cycle. The reference model predicts every output on every clock, so any of these faults is reported in the cycle it first reaches a port.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
    parameter int WOFF_W = 8;
    parameter int BOFF_W = 3;
    parameter int PH_W   = 3;
    parameter int RPL_W  = 7;
    parameter int VOFF_W = 8;

    typedef struct packed {
        logic [WOFF_W-1:0] word_off;
        logic [BOFF_W-1:0] byte_off;
        logic [PH_W-1:0]   sub_off;
        logic              filt_en;
        logic              filt_sel;
        logic [RPL_W-1:0]  reads;
        logic [VOFF_W-1:0] line_off;
    } pan_cfg_t;

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_FETCH = 1'b1} seq_state_e;
endpackage

// File: rtl/pscan_cfg_shadow.sv
module pscan_cfg_shadow
    import pscan_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int STRIDE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                src_bitstream,
    input  pan_cfg_t            host_cfg,
    input  pan_cfg_t            bs_cfg,
    input  logic [ADDR_W-1:0]   base_in,
    input  logic [STRIDE_W-1:0] stride_in,
    output pan_cfg_t            cfg_q,
    output logic [ADDR_W-1:0]   base_q,
    output logic [STRIDE_W-1:0] stride_q
);
    typedef struct packed {
        pan_cfg_t            cfg;
        logic [ADDR_W-1:0]   base;
        logic [STRIDE_W-1:0] stride;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (frame_start) begin
            sh_d.cfg    = src_bitstream ? bs_cfg : host_cfg;
            sh_d.base   = base_in;
            sh_d.stride = stride_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign cfg_q    = sh_q.cfg;
    assign base_q   = sh_q.base;
    assign stride_q = sh_q.stride;

    assert_src_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cfg_q == ($past(src_bitstream) ? $past(bs_cfg) : $past(host_cfg))));
endmodule

// File: rtl/pscan_line_seq.sv
module pscan_line_seq
    import pscan_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [RPL_W-1:0]  reads,
    input  logic              req_ready,
    output logic              req_valid,
    output logic              req_last,
    output logic              line_done,
    output logic              load_line,
    output logic              advance,
    output logic [LINE_W-1:0] line_idx
);
    typedef struct packed {
        seq_state_e        st;
        logic [RPL_W-1:0]  k;
        logic [LINE_W-1:0] line;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic at_last;

    assign at_last = (s_q.k == reads - RPL_W'(1));

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        load_line = 1'b0;
        if (frame_start) begin
            s_d.st   = SEQ_IDLE;
            s_d.k    = '0;
            s_d.line = '0;
        end else begin
            unique case (s_q.st)
                SEQ_IDLE: begin
                    if (line_start) begin
                        if (reads == '0) begin
                            s_d.done = 1'b1;
                            s_d.line = s_q.line + LINE_W'(1);
                        end else begin
                            s_d.st    = SEQ_FETCH;
                            s_d.k     = '0;
                            load_line = 1'b1;
                        end
                    end
                end
                SEQ_FETCH: begin
                    if (req_ready) begin
                        if (at_last) begin
                            s_d.st   = SEQ_IDLE;
                            s_d.done = 1'b1;
                            s_d.line = s_q.line + LINE_W'(1);
                        end else begin
                            s_d.k = s_q.k + RPL_W'(1);
                        end
                    end
                end
                default: s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, k: '0, line: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign req_valid = (s_q.st == SEQ_FETCH);
    assign req_last  = req_valid && at_last;
    assign advance   = req_valid && req_ready;
    assign line_done = s_q.done;
    assign line_idx  = s_q.line;

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !req_valid);
    assert_last_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last && !frame_start) |=> (line_done && !req_valid));
    assert_zero_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && line_start && reads == '0 && !frame_start) |=> (line_done && !req_valid));
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !frame_start) |=> req_valid);
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!req_valid && !line_done && line_idx == '0));
    assert_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && line_start && reads != '0 && !frame_start) |=> req_valid);
endmodule

// File: rtl/pscan_addr_gen.sv
module pscan_addr_gen
    import pscan_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int STRIDE_W = 12,
    parameter int LINE_W   = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_line,
    input  logic                advance,
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [VOFF_W-1:0]   line_off,
    input  logic [WOFF_W-1:0]   word_off,
    input  logic [LINE_W-1:0]   line_idx,
    output logic [ADDR_W-1:0]   addr_q
);
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] row_a;
    logic [ADDR_W-1:0] start_a;

    always_comb begin
        row_a   = ADDR_W'(line_off) + ADDR_W'(line_idx);
        start_a = base + row_a * ADDR_W'(stride) + ADDR_W'(word_off);
        addr_d  = addr_q;
        if (load_line)    addr_d = start_a;
        else if (advance) addr_d = addr_q + ADDR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end
endmodule

// File: rtl/pscan_fetch_gen.sv
module pscan_fetch_gen
    import pscan_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int STRIDE_W = 12,
    parameter int LINE_W   = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                src_bitstream,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride_words,
    input  logic [7:0]          host_word_off,
    input  logic [2:0]          host_byte_off,
    input  logic [2:0]          host_sub_off,
    input  logic                host_filt_en,
    input  logic                host_filt_sel,
    input  logic [6:0]          host_reads,
    input  logic [7:0]          host_line_off,
    input  logic [7:0]          bs_word_off,
    input  logic [2:0]          bs_byte_off,
    input  logic [2:0]          bs_sub_off,
    input  logic                bs_filt_en,
    input  logic                bs_filt_sel,
    input  logic [6:0]          bs_reads,
    input  logic [7:0]          bs_line_off,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                req_last,
    output logic                line_done,
    output logic [2:0]          byte_sel,
    output logic [2:0]          filt_phase,
    output logic                filt_en_o,
    output logic                filt_sel_o
);
    pan_cfg_t            host_cfg, bs_cfg, cfg;
    logic [ADDR_W-1:0]   base_s;
    logic [STRIDE_W-1:0] stride_s;
    logic                load_line, advance;
    logic [LINE_W-1:0]   line_idx;

    assign host_cfg = '{word_off: host_word_off, byte_off: host_byte_off, sub_off: host_sub_off,
                        filt_en: host_filt_en, filt_sel: host_filt_sel, reads: host_reads,
                        line_off: host_line_off};
    assign bs_cfg   = '{word_off: bs_word_off, byte_off: bs_byte_off, sub_off: bs_sub_off,
                        filt_en: bs_filt_en, filt_sel: bs_filt_sel, reads: bs_reads,
                        line_off: bs_line_off};

    pscan_cfg_shadow #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .src_bitstream(src_bitstream),
        .host_cfg(host_cfg), .bs_cfg(bs_cfg), .base_in(base_addr), .stride_in(stride_words),
        .cfg_q(cfg), .base_q(base_s), .stride_q(stride_s)
    );

    pscan_line_seq #(.LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .reads(cfg.reads), .req_ready(req_ready), .req_valid(req_valid), .req_last(req_last),
        .line_done(line_done), .load_line(load_line), .advance(advance), .line_idx(line_idx)
    );

    pscan_addr_gen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_W(LINE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_line(load_line), .advance(advance),
        .base(base_s), .stride(stride_s), .line_off(cfg.line_off), .word_off(cfg.word_off),
        .line_idx(line_idx), .addr_q(req_addr)
    );

    assign byte_sel   = cfg.byte_off;
    assign filt_phase = cfg.filt_en ? cfg.sub_off : '0;
    assign filt_en_o  = cfg.filt_en;
    assign filt_sel_o = cfg.filt_sel;

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !frame_start) |=> (req_valid && $stable(req_addr)));
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_last && !frame_start) |=> (req_addr == $past(req_addr) + ADDR_W'(1)));
    assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_last |-> req_valid);
    assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(byte_sel) && $stable(filt_phase) && $stable(filt_sel_o)));
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |-> (!req_valid && !line_done));
endmodule

// File: tb/pscan_fetch_gen_tb.sv
module pscan_fetch_gen_tb_top;
    localparam int ADDR_W = 24;
    localparam int STRIDE_W = 12;
    localparam int LINE_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, line_start = 1'b0, src_bitstream = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [STRIDE_W-1:0] stride_words = '0;
    logic [7:0] h_woff = '0, b_woff = '0, h_loff = '0, b_loff = '0;
    logic [2:0] h_boff = '0, b_boff = '0, h_sub = '0, b_sub = '0;
    logic h_en = 1'b0, b_en = 1'b0, h_fs = 1'b0, b_fs = 1'b0;
    logic [6:0] h_reads = '0, b_reads = '0;
    logic req_ready = 1'b1;
    logic req_valid, req_last, line_done, filt_en_o, filt_sel_o;
    logic [ADDR_W-1:0] req_addr;
    logic [2:0] byte_sel, filt_phase;

    always #10 clk = ~clk;

    pscan_fetch_gen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .src_bitstream(src_bitstream), .base_addr(base_addr), .stride_words(stride_words),
        .host_word_off(h_woff), .host_byte_off(h_boff), .host_sub_off(h_sub),
        .host_filt_en(h_en), .host_filt_sel(h_fs), .host_reads(h_reads), .host_line_off(h_loff),
        .bs_word_off(b_woff), .bs_byte_off(b_boff), .bs_sub_off(b_sub),
        .bs_filt_en(b_en), .bs_filt_sel(b_fs), .bs_reads(b_reads), .bs_line_off(b_loff),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_last(req_last),
        .line_done(line_done), .byte_sel(byte_sel), .filt_phase(filt_phase),
        .filt_en_o(filt_en_o), .filt_sel_o(filt_sel_o)
    );

    int compared = 0, mismatched = 0;
    string phase_tag = "R10";
    bit bp_mode = 1'b0;
    int bp_cnt = 0;

    // reference model state
    int m_active = 0, m_k = 0, m_line = 0, m_done = 0;
    int s_woff = 0, s_boff = 0, s_sub = 0, s_en = 0, s_fs = 0, s_reads = 0, s_loff = 0;
    longint s_base = 0, s_stride = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_k = 0; m_line = 0; m_done = 0;
            s_woff = 0; s_boff = 0; s_sub = 0; s_en = 0; s_fs = 0; s_reads = 0; s_loff = 0;
            s_base = 0; s_stride = 0;
        end else begin
            m_done = 0;
            if (frame_start) begin
                s_woff  = src_bitstream ? int'(b_woff)  : int'(h_woff);
                s_boff  = src_bitstream ? int'(b_boff)  : int'(h_boff);
                s_sub   = src_bitstream ? int'(b_sub)   : int'(h_sub);
                s_en    = src_bitstream ? int'(b_en)    : int'(h_en);
                s_fs    = src_bitstream ? int'(b_fs)    : int'(h_fs);
                s_reads = src_bitstream ? int'(b_reads) : int'(h_reads);
                s_loff  = src_bitstream ? int'(b_loff)  : int'(h_loff);
                s_base = longint'(base_addr);
                s_stride = longint'(stride_words);
                m_active = 0; m_k = 0; m_line = 0;
            end else if (m_active != 0) begin
                if (req_ready) begin
                    if (m_k == s_reads - 1) begin
                        m_active = 0; m_done = 1; m_line = (m_line + 1) % (1 << LINE_W);
                    end else m_k++;
                end
            end else if (line_start) begin
                if (s_reads == 0) begin
                    m_done = 1; m_line = (m_line + 1) % (1 << LINE_W);
                end else begin
                    m_active = 1; m_k = 0;
                end
            end
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s (phase %s) %s act=%0d exp=%0d at %0t", rq, phase_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        longint ea;
        ea = (s_base + (longint'(s_loff) + longint'(m_line)) * s_stride + longint'(s_woff) + longint'(m_k))
             & ((64'd1 << ADDR_W) - 1);
        chk("R11", "req_valid", longint'(req_valid), longint'(m_active));
        if (m_active != 0) begin
            chk("R3", "req_addr", longint'(req_addr), ea);
            chk("R4", "req_last", longint'(req_last), longint'(m_k == s_reads - 1));
        end else begin
            chk("R4", "req_last_idle", longint'(req_last), 0);
        end
        chk("R6", "line_done", longint'(line_done), longint'(m_done));
        chk("R8", "byte_sel", longint'(byte_sel), longint'(s_boff));
        chk("R8", "filt_phase", longint'(filt_phase), longint'(s_en != 0 ? s_sub : 0));
        chk("R8", "filt_en_o", longint'(filt_en_o), longint'(s_en));
        chk("R8", "filt_sel_o", longint'(filt_sel_o), longint'(s_fs));
        bp_cnt++;
        req_ready = bp_mode ? ((bp_cnt % 3) != 1) : 1'b1;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            mismatched++;
            $display("FAIL R4 watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic new_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic one_line(input bit extra);
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        while (m_active != 0) begin
            line_start = extra;
            @(negedge clk);
            line_start = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", "rst_valid", longint'(req_valid), 0);
        chk("R10", "rst_done", longint'(line_done), 0);
        chk("R10", "rst_last", longint'(req_last), 0);
        chk("R10", "rst_byte", longint'(byte_sel), 0);
        rst_n = 1'b1;
        one_line(1'b0);                       // R10: reads shadow is zero -> done only

        base_addr = 24'h001000; stride_words = 12'd90;
        h_woff = 8'd5;  h_boff = 3'd3; h_sub = 3'd6; h_en = 1'b1; h_fs = 1'b1; h_reads = 7'd4; h_loff = 8'd2;
        b_woff = 8'd20; b_boff = 3'd1; b_sub = 3'd2; b_en = 1'b1; b_fs = 1'b0; b_reads = 7'd3; b_loff = 8'd7;

        phase_tag = "R1"; src_bitstream = 1'b0; new_frame();
        repeat (3) one_line(1'b0);
        src_bitstream = 1'b1; new_frame();
        repeat (2) one_line(1'b0);

        phase_tag = "R7"; bp_mode = 1'b1;
        repeat (3) one_line(1'b0);

        phase_tag = "R2";                      // mid-frame edits must not take effect
        src_bitstream = 1'b0; b_woff = 8'd40; base_addr = 24'h00F000; stride_words = 12'd7;
        repeat (2) one_line(1'b0);
        new_frame(); repeat (2) one_line(1'b0);

        phase_tag = "R9";                      // line starts while busy are ignored
        repeat (2) one_line(1'b1);
        @(negedge clk); line_start = 1'b1;     // frame start aborts a line in progress
        @(negedge clk); line_start = 1'b0;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        repeat (3) @(negedge clk);
        one_line(1'b0);

        phase_tag = "R5"; bp_mode = 1'b0;
        h_reads = 7'd0; new_frame();
        repeat (3) one_line(1'b0);

        phase_tag = "R4";
        h_reads = 7'd1; h_loff = 8'd255; h_woff = 8'd255; new_frame();
        repeat (2) one_line(1'b0);
        h_reads = 7'd127; bp_mode = 1'b1; new_frame();
        one_line(1'b0);
        bp_mode = 1'b0;

        phase_tag = "R8";
        h_en = 1'b0; h_sub = 3'd5; h_boff = 3'd7; h_fs = 1'b0; h_reads = 7'd2; new_frame();
        repeat (2) one_line(1'b0);
        h_en = 1'b1; new_frame();
        one_line(1'b0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule